// File: doc/BRIEF.md
# Programmable Flag GPIO Controller

This block manages a bank of sixteen bidirectional flag pins for a processor core. Each pin can be an input or an output. Output levels are changed through a pair of write-one registers: one raises bits and the other lowers them. A read-modify-write sequence is therefore never needed. Input levels pass through a two-stage synchronizer, and software can read the synchronized values back.

Every pin also has an interrupt path. A mask enables it, a polarity selects active-high or active-low, and a mode chooses level sensing, single-edge sensing or dual-edge sensing. On an input pin the source is the synchronized input level. On an output pin the source is the value being driven, so software can raise an interrupt by writing to its own output. Each edge event is held in a latch until software acknowledges it. A level condition follows its source directly. The pending and enabled conditions of all pins are ORed into a single request line to the core.

When the external data bus is sixteen bits wide, the upper eight pins carry data. The block then removes their flag function: no drive, no interrupt and no readback. The lower eight pins are always flags.

Top module: `pflag_gpio`

## Requirements
- R1: After reset every register reads 0: all pins are inputs, output data is low, interrupts are masked, polarity is active-high and every pin is level-sensed. While reset is held, `pin_oe_o`, `pin_o` and `irq_o` are 0.
- R2: The direction register is at offset 0x0, with bit i = 1 making pin i an output. The register reads back as written, and `pin_oe_o` follows it for every pin whose flag function is enabled.
- R3: Writing offset 0x1 sets the output-data bits that are 1 in the write data. Writing offset 0x2 clears those bits. Bits written as 0 keep their value. Both offsets read back the output data, and `pin_o` shows it for enabled pins.
- R4: Offset 0x3 reads the synchronized input level of each enabled pin. A change on `pin_i` is visible there after the second rising clock edge, and not after the first.
- R5: The interrupt mask is set by writing 1 bits to offset 0x4 and cleared by writing 1 bits to offset 0x5. Both offsets read back the mask.
- R6: The polarity register is at offset 0x6, with 1 meaning active-low or falling edge. For a pin whose sense bit (offset 0x7) is 0, the pending bit equals the source level XOR the polarity, with no latching.
- R7: For a pin whose sense bit is 1 and whose both-edges bit (offset 0x8) is 0, a rising source edge (polarity 0) or a falling edge (polarity 1) sets its latch. The opposite edge does not. The latch holds until software writes a 1 to that bit at offset 0x9.
- R8: When the both-edges bit is 1, an edge-sensed pin latches on rising and on falling edges, whatever its polarity.
- R9: On an output pin the interrupt source is the driven output-data bit, in both level and edge modes.
- R10: While `wide_bus_i` is 1, pins from the shared base (8) upward are not driven (`pin_oe_o` and `pin_o` are 0), read 0 at offset 0x3, and add nothing to the pending bits or to `irq_o`. The lower pins are unaffected.
- R11: Offset 0x9 reads the per-pin pending bits. `irq_o` is the OR over all pins of pending AND mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide_bus_i | input | 1 | 1 = upper pins serve as external data lines |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 4 | Register offset |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for `bus_addr_i` (combinational) |
| pin_i | input | 16 | Pad input levels (asynchronous) |
| pin_o | output | 16 | Pad output levels |
| pin_oe_o | output | 16 | Pad output enables |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A register write takes effect at the clock edge that samples it. Register readback, `pin_o` and `pin_oe_o` follow in that same cycle, and so does a level interrupt from an output pin. An edge on an output pin reaches `irq_o` one edge later. An input-pin change needs two edges to reach the readback and a level interrupt, and three edges to set an edge latch. The bench therefore waits three falling edges after each vector's write edge before it reads, which covers the longest path. The synchronizer latency itself is checked one edge at a time, so a missing stage or an extra stage is detected.

// File: rtl/pflag_pkg.sv
package pflag_pkg;

   localparam int ADDR_W = 4;

   typedef enum logic [ADDR_W-1:0] {
      A_DIR   = 4'h0,
      A_OSET  = 4'h1,
      A_OCLR  = 4'h2,
      A_PSTAT = 4'h3,
      A_MSET  = 4'h4,
      A_MCLR  = 4'h5,
      A_POL   = 4'h6,
      A_SENSE = 4'h7,
      A_BOTH  = 4'h8,
      A_PEND  = 4'h9
   } reg_addr_e;

endpackage

// File: rtl/pflag_sync.sv
module pflag_sync #(
   parameter int WIDTH  = 16,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      end else begin
         stage_q[0] <= d_i;
         for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      end
   end

   assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/pflag_irq_slice.sv
module pflag_irq_slice (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic src_i,
   input  logic pol_i,
   input  logic sense_i,
   input  logic both_i,
   input  logic ack_i,
   output logic edge_o,
   output logic pend_o
);

   logic prev_q;
   logic edge_q;
   logic rise, fall, hit;

   always_comb begin
      rise = src_i & ~prev_q;
      fall = ~src_i & prev_q;
      if (both_i) hit = rise | fall;
      else        hit = pol_i ? fall : rise;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         edge_q <= 1'b0;
      end else begin
         prev_q <= src_i;
         if (en_i && sense_i && hit) edge_q <= 1'b1;
         else if (ack_i)             edge_q <= 1'b0;
      end
   end

   assign edge_o = edge_q;
   assign pend_o = en_i & (sense_i ? edge_q : (src_i ^ pol_i));

endmodule

// File: rtl/pflag_regs.sv
module pflag_regs
   import pflag_pkg::*;
#(
   parameter int NUM_PINS = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_i,
   input  logic [ADDR_W-1:0]   addr_i,
   input  logic [NUM_PINS-1:0] wdata_i,
   input  logic [NUM_PINS-1:0] sync_i,
   input  logic [NUM_PINS-1:0] pend_i,
   output logic [NUM_PINS-1:0] rdata_o,
   output logic [NUM_PINS-1:0] dir_o,
   output logic [NUM_PINS-1:0] out_o,
   output logic [NUM_PINS-1:0] mask_o,
   output logic [NUM_PINS-1:0] pol_o,
   output logic [NUM_PINS-1:0] sense_o,
   output logic [NUM_PINS-1:0] both_o,
   output logic [NUM_PINS-1:0] ack_o
);

   logic [NUM_PINS-1:0] dir_q, out_q, mask_q, pol_q, sense_q, both_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q   <= '0;
         out_q   <= '0;
         mask_q  <= '0;
         pol_q   <= '0;
         sense_q <= '0;
         both_q  <= '0;
      end else if (wr_i) begin
         case (addr_i)
            A_DIR:   dir_q   <= wdata_i;
            A_OSET:  out_q   <= out_q | wdata_i;
            A_OCLR:  out_q   <= out_q & ~wdata_i;
            A_MSET:  mask_q  <= mask_q | wdata_i;
            A_MCLR:  mask_q  <= mask_q & ~wdata_i;
            A_POL:   pol_q   <= wdata_i;
            A_SENSE: sense_q <= wdata_i;
            A_BOTH:  both_q  <= wdata_i;
            default: ;
         endcase
      end
   end

   always_comb begin
      case (addr_i)
         A_DIR:           rdata_o = dir_q;
         A_OSET, A_OCLR:  rdata_o = out_q;
         A_PSTAT:         rdata_o = sync_i;
         A_MSET, A_MCLR:  rdata_o = mask_q;
         A_POL:           rdata_o = pol_q;
         A_SENSE:         rdata_o = sense_q;
         A_BOTH:          rdata_o = both_q;
         A_PEND:          rdata_o = pend_i;
         default:         rdata_o = '0;
      endcase
   end

   assign ack_o   = (wr_i && addr_i == A_PEND) ? wdata_i : '0;
   assign dir_o   = dir_q;
   assign out_o   = out_q;
   assign mask_o  = mask_q;
   assign pol_o   = pol_q;
   assign sense_o = sense_q;
   assign both_o  = both_q;

endmodule

// File: rtl/pflag_gpio.sv
module pflag_gpio
   import pflag_pkg::*;
#(
   parameter int NUM_PINS    = 16,
   parameter int SHARED_BASE = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wide_bus_i,
   input  logic                bus_wr_i,
   input  logic [ADDR_W-1:0]   bus_addr_i,
   input  logic [NUM_PINS-1:0] bus_wdata_i,
   output logic [NUM_PINS-1:0] bus_rdata_o,
   input  logic [NUM_PINS-1:0] pin_i,
   output logic [NUM_PINS-1:0] pin_o,
   output logic [NUM_PINS-1:0] pin_oe_o,
   output logic                irq_o
);

   if (NUM_PINS < 1 || NUM_PINS > 32) begin : g_bad_num_pins
      $error("pflag_gpio: NUM_PINS must lie in 1..32");
   end
   if (SHARED_BASE < 0 || SHARED_BASE > NUM_PINS) begin : g_bad_shared_base
      $error("pflag_gpio: SHARED_BASE must lie in 0..NUM_PINS");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pflag_gpio: SYNC_STAGES must be at least 2");
   end

   logic [NUM_PINS-1:0] en;
   logic [NUM_PINS-1:0] sync_raw, sync_vis;
   logic [NUM_PINS-1:0] dir_q, out_q, mask_q, pol_q, sense_q, both_q, ack;
   logic [NUM_PINS-1:0] src, edge_lat, pend_vec;

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_en
      if (i < SHARED_BASE) begin : g_fixed
         assign en[i] = 1'b1;
      end else begin : g_shared
         assign en[i] = ~wide_bus_i;
      end
   end

   pflag_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pin_i),
      .q_o   (sync_raw)
   );

   assign sync_vis = sync_raw & en;

   pflag_regs #(.NUM_PINS(NUM_PINS)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (bus_wr_i),
      .addr_i  (bus_addr_i),
      .wdata_i (bus_wdata_i),
      .sync_i  (sync_vis),
      .pend_i  (pend_vec),
      .rdata_o (bus_rdata_o),
      .dir_o   (dir_q),
      .out_o   (out_q),
      .mask_o  (mask_q),
      .pol_o   (pol_q),
      .sense_o (sense_q),
      .both_o  (both_q),
      .ack_o   (ack)
   );

   assign src = (dir_q & out_q) | (~dir_q & sync_raw);

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      pflag_irq_slice u_slice (
         .clk     (clk),
         .rst_n   (rst_n),
         .en_i    (en[i]),
         .src_i   (src[i]),
         .pol_i   (pol_q[i]),
         .sense_i (sense_q[i]),
         .both_i  (both_q[i]),
         .ack_i   (ack[i]),
         .edge_o  (edge_lat[i]),
         .pend_o  (pend_vec[i])
      );
   end

   assign pin_oe_o = dir_q & en;
   assign pin_o    = out_q & en;
   assign irq_o    = |(pend_vec & mask_q);

endmodule

// File: rtl/pflag_gpio_chk.sv
module pflag_gpio_chk
   import pflag_pkg::*;
#(
   parameter int NUM_PINS    = 16,
   parameter int SHARED_BASE = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                wide_bus_i,
   input logic                bus_wr_i,
   input logic [ADDR_W-1:0]   bus_addr_i,
   input logic [NUM_PINS-1:0] bus_wdata_i,
   input logic [NUM_PINS-1:0] pin_o,
   input logic [NUM_PINS-1:0] pin_oe_o,
   input logic                irq_o,
   input logic [NUM_PINS-1:0] out_q,
   input logic [NUM_PINS-1:0] mask_q,
   input logic [NUM_PINS-1:0] edge_lat,
   input logic [NUM_PINS-1:0] pend_vec
);

   logic [NUM_PINS-1:0] upper;
   always_comb begin
      for (int i = 0; i < NUM_PINS; i++) upper[i] = (i >= SHARED_BASE);
   end

   p_oe_after_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_i && bus_addr_i == A_DIR) |=>
         (wide_bus_i || pin_oe_o == $past(bus_wdata_i)));

   p_set_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_i && bus_addr_i == A_OSET) |=>
         ((out_q & $past(bus_wdata_i)) == $past(bus_wdata_i)));

   p_clear_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_i && bus_addr_i == A_OCLR) |=>
         ((out_q & $past(bus_wdata_i)) == '0));

   p_mask_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_i && bus_addr_i == A_MSET) |=>
         ((mask_q & $past(bus_wdata_i)) == $past(bus_wdata_i)));

   p_mask_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_i && bus_addr_i == A_MCLR) |=>
         ((mask_q & $past(bus_wdata_i)) == '0));

   p_edge_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr_i && bus_addr_i == A_PEND) |=>
         (($past(edge_lat) & ~edge_lat) == '0));

   p_upper_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wide_bus_i |-> (((pin_oe_o | pin_o | pend_vec) & upper) == '0));

   p_irq_has_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> ((pend_vec & mask_q) != '0));

   p_irq_quiet_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0) |-> !irq_o);

endmodule

bind pflag_gpio pflag_gpio_chk #(.NUM_PINS(NUM_PINS), .SHARED_BASE(SHARED_BASE)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wide_bus_i  (wide_bus_i),
   .bus_wr_i    (bus_wr_i),
   .bus_addr_i  (bus_addr_i),
   .bus_wdata_i (bus_wdata_i),
   .pin_o       (pin_o),
   .pin_oe_o    (pin_oe_o),
   .irq_o       (irq_o),
   .out_q       (out_q),
   .mask_q      (mask_q),
   .edge_lat    (edge_lat),
   .pend_vec    (pend_vec)
);

// File: tb/test_pflag_gpio.sv
module test_pflag_gpio;

   localparam int N   = 16;
   localparam int NV  = 30;
   localparam int VW  = 66;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wide_bus = 1'b0;
   logic          bus_wr = 1'b0;
   logic [3:0]    bus_addr = 4'h0;
   logic [N-1:0]  bus_wdata = '0;
   logic [N-1:0]  bus_rdata;
   logic [N-1:0]  pin_in = '0;
   logic [N-1:0]  pin_out, pin_oe;
   logic          irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   pflag_gpio i_pflag_gpio (
      .clk         (clk),
      .rst_n       (rst_n),
      .wide_bus_i  (wide_bus),
      .bus_wr_i    (bus_wr),
      .bus_addr_i  (bus_addr),
      .bus_wdata_i (bus_wdata),
      .bus_rdata_o (bus_rdata),
      .pin_i       (pin_in),
      .pin_o       (pin_out),
      .pin_oe_o    (pin_oe),
      .irq_o       (irq)
   );

   // {wr, addr, wdata, pins, read addr, expected read, expected irq, requirement}
   localparam logic [VW-1:0] TBL [NV] = '{
      {1'b0, 4'h0, 16'h0000, 16'hA5A5, 4'h3, 16'hA5A5, 1'b0, 8'd4},  // R4
      {1'b1, 4'h0, 16'h00FF, 16'hA5A5, 4'h0, 16'h00FF, 1'b0, 8'd2},  // R2
      {1'b1, 4'h1, 16'h0081, 16'hA5A5, 4'h1, 16'h0081, 1'b0, 8'd3},  // R3
      {1'b1, 4'h1, 16'h0003, 16'hA5A5, 4'h2, 16'h0083, 1'b0, 8'd3},  // R3
      {1'b1, 4'h2, 16'h0080, 16'hA5A5, 4'h1, 16'h0003, 1'b0, 8'd3},  // R3
      {1'b0, 4'h0, 16'h0000, 16'hA5A5, 4'h9, 16'hA503, 1'b0, 8'd6},  // R6
      {1'b1, 4'h4, 16'h0100, 16'hA5A5, 4'h9, 16'hA503, 1'b1, 8'd11}, // R11
      {1'b0, 4'h0, 16'h0000, 16'hA4A5, 4'h9, 16'hA403, 1'b0, 8'd6},  // R6
      {1'b1, 4'h6, 16'h0100, 16'hA4A5, 4'h9, 16'hA503, 1'b1, 8'd6},  // R6
      {1'b1, 4'h5, 16'h0100, 16'hA4A5, 4'h4, 16'h0000, 1'b0, 8'd5},  // R5
      {1'b1, 4'h7, 16'h0200, 16'hA4A5, 4'h9, 16'hA503, 1'b0, 8'd7},  // R7
      {1'b1, 4'h4, 16'h0200, 16'hA4A5, 4'h5, 16'h0200, 1'b0, 8'd5},  // R5
      {1'b0, 4'h0, 16'h0000, 16'hA6A5, 4'h9, 16'hA703, 1'b1, 8'd7},  // R7
      {1'b0, 4'h0, 16'h0000, 16'hA4A5, 4'h9, 16'hA703, 1'b1, 8'd7},  // R7
      {1'b1, 4'h9, 16'h0200, 16'hA4A5, 4'h9, 16'hA503, 1'b0, 8'd7},  // R7
      {1'b1, 4'h6, 16'h0300, 16'hA4A5, 4'h9, 16'hA503, 1'b0, 8'd7},  // R7
      {1'b0, 4'h0, 16'h0000, 16'hA6A5, 4'h9, 16'hA503, 1'b0, 8'd7},  // R7
      {1'b0, 4'h0, 16'h0000, 16'hA4A5, 4'h9, 16'hA703, 1'b1, 8'd7},  // R7
      {1'b1, 4'h9, 16'h0200, 16'hA4A5, 4'h9, 16'hA503, 1'b0, 8'd7},  // R7
      {1'b1, 4'h8, 16'h0200, 16'hA4A5, 4'h9, 16'hA503, 1'b0, 8'd8},  // R8
      {1'b0, 4'h0, 16'h0000, 16'hA6A5, 4'h9, 16'hA703, 1'b1, 8'd8},  // R8
      {1'b1, 4'h9, 16'h0200, 16'hA6A5, 4'h9, 16'hA503, 1'b0, 8'd8},  // R8
      {1'b0, 4'h0, 16'h0000, 16'hA4A5, 4'h9, 16'hA703, 1'b1, 8'd8},  // R8
      {1'b1, 4'h9, 16'h0200, 16'hA4A5, 4'h9, 16'hA503, 1'b0, 8'd8},  // R8
      {1'b1, 4'h7, 16'h0204, 16'hA4A5, 4'h9, 16'hA503, 1'b0, 8'd9},  // R9
      {1'b1, 4'h4, 16'h0004, 16'hA4A5, 4'h4, 16'h0204, 1'b0, 8'd9},  // R9
      {1'b1, 4'h1, 16'h0004, 16'hA4A5, 4'h9, 16'hA507, 1'b1, 8'd9},  // R9
      {1'b1, 4'h9, 16'h0004, 16'hA4A5, 4'h9, 16'hA503, 1'b0, 8'd9},  // R9
      {1'b1, 4'h4, 16'h0001, 16'hA4A5, 4'h4, 16'h0205, 1'b1, 8'd9},  // R9
      {1'b1, 4'h2, 16'h0001, 16'hA4A5, 4'h9, 16'hA502, 1'b0, 8'd9}   // R9
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [N-1:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input logic [3:0] a, input logic [N-1:0] exp);
      bus_addr = a;
      #1;
      chk(tag, 32'(bus_rdata), 32'(exp));
   endtask

   initial begin
      repeat (40000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not finish act=timeout exp=finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1 pin_oe in reset", 32'(pin_oe), 32'h0);
      chk("R1 irq in reset", 32'(irq), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int a = 0; a < 10; a++) rd_chk("R1 register reset value", 4'(a), 16'h0000);
      chk("R1 pin_o after reset", 32'(pin_out), 32'h0);

      // vector table
      for (int k = 0; k < NV; k++) begin
         logic [VW-1:0] v;
         v = TBL[k];
         @(negedge clk);
         pin_in = v[44:29];
         if (v[65]) begin
            bus_wr = 1'b1; bus_addr = v[64:61]; bus_wdata = v[60:45];
            @(negedge clk);
            bus_wr = 1'b0;
         end
         repeat (3) @(negedge clk);
         bus_addr = v[28:25];
         #1;
         n_chk++;
         if (bus_rdata !== v[24:9] || irq !== v[8]) begin
            n_bad++;
            $display("FAIL R%0d vector %0d act rdata=%h irq=%b exp rdata=%h irq=%b",
                     v[7:0], k, bus_rdata, irq, v[24:9], v[8]);
         end
      end

      // R2 / R3: pad outputs after table
      chk("R2 pin_oe follows direction", 32'(pin_oe), 32'h00FF);
      chk("R3 pin_o shows output data", 32'(pin_out), 32'h0006);

      // R10: wide-bus takeover of upper pins
      wr(4'h0, 16'hFFFF);
      wr(4'h1, 16'hFF00);
      wr(4'h4, 16'hFF00);
      repeat (3) @(negedge clk);
      chk("R2 all pins driven", 32'(pin_oe), 32'hFFFF);
      chk("R3 upper outputs high", 32'(pin_out), 32'hFF06);
      chk("R11 upper pins request", 32'(irq), 32'h1);
      wide_bus = 1'b1;
      repeat (3) @(negedge clk);
      chk("R10 upper oe released", 32'(pin_oe), 32'h00FF);
      chk("R10 upper pin_o low", 32'(pin_out), 32'h0006);
      chk("R10 upper interrupts removed", 32'(irq), 32'h0);
      rd_chk("R10 upper status reads 0", 4'h3, 16'h00A5);
      wide_bus = 1'b0;
      repeat (2) @(negedge clk);
      #1;
      chk("R10 upper restored", 32'(irq), 32'h1);

      // R4: synchronizer latency
      wr(4'h0, 16'h0000);
      pin_in = 16'h0000;
      repeat (3) @(negedge clk);
      pin_in = 16'h0001;
      @(negedge clk);
      rd_chk("R4 not visible after one edge", 4'h3, 16'h0000);
      @(negedge clk);
      rd_chk("R4 visible after two edges", 4'h3, 16'h0001);

      // R1: reset in mid-run
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R1 oe cleared by reset", 32'(pin_oe), 32'h0);
      chk("R1 irq cleared by reset", 32'(irq), 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      rd_chk("R1 mask cleared", 4'h4, 16'h0000);
      rd_chk("R1 output data cleared", 4'h1, 16'h0000);
      rd_chk("R1 sense cleared", 4'h7, 16'h0000);
      rd_chk("R1 polarity cleared", 4'h6, 16'h0000);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule